// File: doc/BRIEF.md
# Mirrored Address Mapper

This block sits between a processor load/store port and one compact byte-wide backing memory. It takes a processor byte address, keeps its low 24 bits, and works out where that byte lives in the memory. The memory holds three areas packed back to back: a ROM area, an external RAM area and a small high area for internal RAM and peripherals. Inside each area the block applies aliasing rules. The ROM repeats throughout the first megabyte. The external RAM is moved down so that it follows the ROM. Each of the two 4 KB high areas exposes only 1 KB, repeated four times. Addresses in the unmapped gap between the low region and the high region raise a fault.

A request carries 1, 2 or 4 bytes. The block handles it one byte per cycle against the byte memory and assembles the bytes little-endian. It translates every byte on its own, so an access that straddles an area boundary or the gap is handled correctly. A byte that falls in the gap never reaches the memory. Such a byte reads as zero and marks the whole response as faulted.

Requests and responses use valid/ready streams. The request is taken when `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the response has been taken, so only one request is ever in flight. The response stays valid, with stable data and fault, until `rsp_ready` is high at a clock edge. The three window settings (ROM size, low-region end, high-region start) are plain registers loaded with a one-cycle `cfg_load` pulse between transactions.

Top module: `mirrored_addr_mapper`

## Requirements
- R1: Only bits 23:0 of `req_addr` take part in translation. Bits 31:24 have no effect, and byte addresses of a multi-byte access wrap modulo 2^24.
- R2: After reset the windows are: ROM size 0x8000, low-region end 0x200000, high-region start 0xFFE000. `req_ready` is 1, and `rsp_valid` and `mem_en` are 0.
- R3: A byte address below 0x100000 (and below the low-region end) maps to memory offset address AND (rom_size − 1).
- R4: A byte address from 0x100000 up to, but not including, the low-region end maps to offset address + rom_size − 0x100000.
- R5: A byte address at or above the high-region start is first masked: with 0xFFF3FF if it is at or above 0xFFF000, with 0xFFE3FF if it is at or above 0xFFE000, and not at all otherwise. It then maps to offset (masked − high_start) + rom_size + (low_end − 0x100000).
- R6: A byte address at or above the low-region end and below the high-region start is in the gap. For such a byte `mem_en` stays low and no write reaches memory. The byte reads as 0, and `rsp_fault` is 1 for that response.
- R7: `req_size` 0 moves 1 byte, 1 moves 2 bytes, and 2 or 3 moves 4 bytes. Byte k of the access sits at address + k and occupies data bits 8k+7:8k. Read data bits above the access size are 0.
- R8: A `cfg_load` whose `cfg_low_end` is below 0x100000 is refused, and all three window settings keep their previous values. Otherwise all three are taken.
- R9: Each byte of a multi-byte access is translated separately. Bytes outside the gap complete normally even when other bytes of the same access fault.
- R10: `req_ready` falls after acceptance and stays low until the response is taken. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_rdata` and `rsp_fault` hold.
- R11: An accepted access drives exactly one memory cycle per byte that is not in the gap, in ascending address order. `mem_en` is never high while the block is idle or presenting a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load pulse for the window settings |
| cfg_rom_size | input | 24 | ROM size in bytes (power of two) |
| cfg_low_end | input | 24 | First address above the low region |
| cfg_high_start | input | 24 | First address of the high region |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_addr | input | 32 | Processor byte address |
| req_size | input | 2 | Size code: 0=1 byte, 1=2 bytes, 2/3=4 bytes |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store data, little-endian |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Load data, little-endian, zero-extended |
| rsp_fault | output | 1 | At least one byte fell in the gap |
| mem_en | output | 1 | Backing memory byte access strobe |
| mem_we | output | 1 | Backing memory write enable |
| mem_addr | output | 24 | Backing memory byte offset |
| mem_wdata | output | 8 | Byte to store |
| mem_rdata | input | 8 | Byte read, valid in the cycle `mem_en` is high |

## Verification
The hardest situation to reach is an access split across a boundary, where some bytes land in real memory and others land in the gap. Only this case shows that translation and fault marking are done per byte and not per request. The stimulus places 2- and 4-byte accesses two bytes below the low-region end and two bytes below the high-region start. It then reads the surviving bytes back through a mirrored alias, which proves which memory offsets were written and which were suppressed. A refused configuration load is the other hard case, because it leaves no trace of its own. It is followed by an access whose mapping differs between the old and the new settings.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  localparam int AW = 24;
  localparam int DW = 32;
  localparam int NBYTES = DW / 8;
  localparam int IDX_W = $clog2(NBYTES);

  localparam logic [AW-1:0] ONE_MEG    = 24'h100000;
  localparam logic [AW-1:0] HI_IO_BASE = 24'hFFF000;
  localparam logic [AW-1:0] HI_IO_MASK = 24'hFFF3FF;
  localparam logic [AW-1:0] HI_RAM_BASE = 24'hFFE000;
  localparam logic [AW-1:0] HI_RAM_MASK = 24'hFFE3FF;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_RESP = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic [AW-1:0] rom_size;
    logic [AW-1:0] low_end;
    logic [AW-1:0] high_start;
  } win_cfg_t;
endpackage

// File: rtl/mapper_cfg.sv
module mapper_cfg
  import mapper_pkg::*;
#(
  parameter logic [AW-1:0] DEF_ROM_SIZE   = 24'h008000,
  parameter logic [AW-1:0] DEF_LOW_END    = 24'h200000,
  parameter logic [AW-1:0] DEF_HIGH_START = 24'hFFE000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  win_cfg_t      load_val,
  output win_cfg_t      cur,
  output logic [AW-1:0] rom_mask,
  output logic [AW-1:0] high_base
);
  win_cfg_t cfg_q;
  logic     accept;

  assign accept = load && (load_val.low_end >= ONE_MEG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.rom_size   <= DEF_ROM_SIZE;
      cfg_q.low_end    <= DEF_LOW_END;
      cfg_q.high_start <= DEF_HIGH_START;
    end else if (accept) begin
      cfg_q <= load_val;
    end
  end

  assign cur       = cfg_q;
  assign rom_mask  = cfg_q.rom_size - 24'd1;
  assign high_base = cfg_q.rom_size + (cfg_q.low_end - ONE_MEG);

  // R8
  low_end_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (load_val.low_end < ONE_MEG)) |=> $stable(cfg_q));
endmodule

// File: rtl/mapper_xlate.sv
module mapper_xlate
  import mapper_pkg::*;
(
  input  logic [AW-1:0] byte_addr,
  input  win_cfg_t      cfg,
  input  logic [AW-1:0] rom_mask,
  input  logic [AW-1:0] high_base,
  output logic [AW-1:0] offset,
  output logic          in_gap
);
  logic [AW-1:0] hi_masked;

  always_comb begin
    if (byte_addr >= HI_IO_BASE)       hi_masked = byte_addr & HI_IO_MASK;
    else if (byte_addr >= HI_RAM_BASE) hi_masked = byte_addr & HI_RAM_MASK;
    else                               hi_masked = byte_addr;
  end

  always_comb begin
    in_gap = 1'b0;
    offset = '0;
    if (byte_addr < cfg.low_end) begin
      if (byte_addr < ONE_MEG) offset = byte_addr & rom_mask;
      else                     offset = byte_addr + cfg.rom_size - ONE_MEG;
    end else if (byte_addr >= cfg.high_start) begin
      offset = (hi_masked - cfg.high_start) + high_base;
    end else begin
      in_gap = 1'b1;
    end
  end
endmodule

// File: rtl/mapper_seq.sv
module mapper_seq
  import mapper_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr24,
  input  logic [1:0]      req_size,
  input  logic            req_write,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_rdata,
  output logic            rsp_fault,
  output logic [AW-1:0]   byte_addr,
  input  logic [AW-1:0]   byte_off,
  input  logic            byte_gap,
  output logic            mem_en,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [7:0]      mem_wdata,
  input  logic [7:0]      mem_rdata
);
  seq_state_t       state_q;
  logic [AW-1:0]    base_q;
  logic [IDX_W-1:0] idx_q, last_q;
  logic             wr_q, fault_q;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic [4:0]       lane;
  logic             running, accept;

  assign running   = (state_q == ST_RUN);
  assign accept    = req_valid && req_ready;
  assign lane      = {idx_q, 3'b000};
  assign byte_addr = base_q + {{(AW-IDX_W){1'b0}}, idx_q};

  assign mem_en    = running && !byte_gap;
  assign mem_we    = mem_en && wr_q;
  assign mem_addr  = byte_gap ? '0 : byte_off;
  assign mem_wdata = wdata_q[lane +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      idx_q   <= '0;
      last_q  <= '0;
      wr_q    <= 1'b0;
      fault_q <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          base_q  <= req_addr24;
          idx_q   <= '0;
          last_q  <= req_size[1] ? 2'd3 : {1'b0, req_size[0]};
          wr_q    <= req_write;
          wdata_q <= req_wdata;
          rdata_q <= '0;
          fault_q <= 1'b0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (!wr_q) rdata_q[lane +: 8] <= byte_gap ? 8'h00 : mem_rdata;
          if (byte_gap) fault_q <= 1'b1;
          if (idx_q == last_q) state_q <= ST_RESP;
          else idx_q <= idx_q + 1'b1;
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_rdata = rdata_q;
  assign rsp_fault = fault_q;

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_fault)));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R11
  mem_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (!req_ready && !rsp_valid));

  // R6
  gap_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && byte_gap) |=> rsp_fault);
endmodule

// File: rtl/mirrored_addr_mapper.sv
module mirrored_addr_mapper
  import mapper_pkg::*;
#(
  parameter logic [23:0] DEF_ROM_SIZE   = 24'h008000,
  parameter logic [23:0] DEF_LOW_END    = 24'h200000,
  parameter logic [23:0] DEF_HIGH_START = 24'hFFE000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_load,
  input  logic [23:0] cfg_rom_size,
  input  logic [23:0] cfg_low_end,
  input  logic [23:0] cfg_high_start,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic        req_write,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  output logic        rsp_fault,
  output logic        mem_en,
  output logic        mem_we,
  output logic [23:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);
  win_cfg_t      cur_cfg, load_cfg;
  logic [AW-1:0] rom_mask, high_base;
  logic [AW-1:0] byte_addr, byte_off;
  logic          byte_gap;
  logic          unused_addr_hi;

  assign unused_addr_hi = ^req_addr[31:AW];

  assign load_cfg.rom_size   = cfg_rom_size;
  assign load_cfg.low_end    = cfg_low_end;
  assign load_cfg.high_start = cfg_high_start;

  mapper_cfg #(
    .DEF_ROM_SIZE  (DEF_ROM_SIZE),
    .DEF_LOW_END   (DEF_LOW_END),
    .DEF_HIGH_START(DEF_HIGH_START)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_load),
    .load_val (load_cfg),
    .cur      (cur_cfg),
    .rom_mask (rom_mask),
    .high_base(high_base)
  );

  mapper_xlate u_xlate (
    .byte_addr(byte_addr),
    .cfg      (cur_cfg),
    .rom_mask (rom_mask),
    .high_base(high_base),
    .offset   (byte_off),
    .in_gap   (byte_gap)
  );

  mapper_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr24(req_addr[AW-1:0]),
    .req_size  (req_size),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .rsp_fault (rsp_fault),
    .byte_addr (byte_addr),
    .byte_off  (byte_off),
    .byte_gap  (byte_gap),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );
endmodule

// File: tb/mirrored_addr_mapper_tb.sv
module mirrored_addr_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [23:0] cfg_rom_size = '0, cfg_low_end = '0, cfg_high_start = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic        req_ready, rsp_valid, rsp_fault, mem_en, mem_we;
  logic [31:0] req_addr = '0, req_wdata = '0, rsp_rdata;
  logic [1:0]  req_size = '0;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  mirrored_addr_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_rom_size(cfg_rom_size),
    .cfg_low_end(cfg_low_end), .cfg_high_start(cfg_high_start),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_fault(rsp_fault), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // byte memory model and access monitor
  logic [7:0] store [int];
  int         nacc;
  logic [23:0] first_off;
  bit         seen;

  always @(posedge clk) begin
    if (mem_en) begin
      if (!seen) first_off = mem_addr;
      seen = 1'b1;
      nacc = nacc + 1;
      if (mem_we) store[int'(mem_addr)] = mem_wdata;
    end
  end

  always @(negedge clk) begin
    if (store.exists(int'(mem_addr))) mem_rdata <= store[int'(mem_addr)];
    else mem_rdata <= 8'h00;
  end

  task automatic check(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  logic [31:0] got_rd;
  logic        got_fault;

  task automatic txn(input logic [31:0] a, input logic [1:0] sz, input logic wr, input logic [31:0] wd);
    nacc = 0; seen = 1'b0; first_off = 24'hFFFFFF;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    got_rd = rsp_rdata; got_fault = rsp_fault;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic load_cfg(input logic [23:0] rs, input logic [23:0] le, input logic [23:0] hs);
    @(negedge clk);
    cfg_load = 1'b1; cfg_rom_size = rs; cfg_low_end = le; cfg_high_start = hs;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  size;
    logic        wr;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic        exp_fault;
    logic [23:0] exp_off;
    logic [2:0]  exp_nacc;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{32'h00000100, 2'd2, 1'b1, 32'h44332211, 32'h0, 1'b0, 24'h000100, 3'd4, 4'd7},  // R7 store
    '{32'h00008100, 2'd2, 1'b0, 32'h0, 32'h44332211, 1'b0, 24'h000100, 3'd4, 4'd3},  // R3 alias, R2 rom size
    '{32'h000F8102, 2'd0, 1'b0, 32'h0, 32'h00000033, 1'b0, 24'h000102, 3'd1, 4'd3},  // R3
    '{32'h00000101, 2'd1, 1'b0, 32'h0, 32'h00003322, 1'b0, 24'h000101, 3'd2, 4'd7},  // R7 halfword
    '{32'h00100000, 2'd1, 1'b1, 32'h0000BEEF, 32'h0, 1'b0, 24'h008000, 3'd2, 4'd4},  // R4
    '{32'hAB100000, 2'd1, 1'b0, 32'h0, 32'h0000BEEF, 1'b0, 24'h008000, 3'd2, 4'd1},  // R1 upper bits
    '{32'h001FFFFF, 2'd0, 1'b0, 32'h0, 32'h00000000, 1'b0, 24'h107FFF, 3'd1, 4'd4},  // R4 top, R2 low end
    '{32'h00200000, 2'd0, 1'b1, 32'h00000077, 32'h0, 1'b1, 24'hFFFFFF, 3'd0, 4'd6},  // R6 write dropped
    '{32'h00500000, 2'd2, 1'b0, 32'h0, 32'h00000000, 1'b1, 24'hFFFFFF, 3'd0, 4'd6},  // R6 read zero
    '{32'h00FFE004, 2'd2, 1'b1, 32'hCAFEF00D, 32'h0, 1'b0, 24'h108004, 3'd4, 4'd5},  // R5, R2 high start
    '{32'h00FFEC04, 2'd2, 1'b0, 32'h0, 32'hCAFEF00D, 1'b0, 24'h108004, 3'd4, 4'd5},  // R5 ram mirror
    '{32'h00FFF7FF, 2'd0, 1'b1, 32'h0000005A, 32'h0, 1'b0, 24'h1093FF, 3'd1, 4'd5},  // R5 io mask
    '{32'h00FFFFFF, 2'd0, 1'b0, 32'h0, 32'h0000005A, 1'b0, 24'h1093FF, 3'd1, 4'd5},  // R5 io mirror
    '{32'h001FFFFE, 2'd1, 1'b1, 32'h00001234, 32'h0, 1'b0, 24'h107FFE, 3'd2, 4'd4},  // R4
    '{32'h001FFFFE, 2'd2, 1'b0, 32'h0, 32'h00001234, 1'b1, 24'h107FFE, 3'd2, 4'd9},  // R9 low edge
    '{32'h00FFDFFE, 2'd2, 1'b1, 32'hDDCCBBAA, 32'h0, 1'b1, 24'h108000, 3'd2, 4'd9},  // R9 high edge
    '{32'h00FFE400, 2'd1, 1'b0, 32'h0, 32'h0000DDCC, 1'b0, 24'h108000, 3'd2, 4'd9},  // R9 readback
    '{32'hFFFFFFFF, 2'd0, 1'b0, 32'h0, 32'h0000005A, 1'b0, 24'h1093FF, 3'd1, 4'd1},  // R1
    '{32'h00000100, 2'd3, 1'b0, 32'h0, 32'h44332211, 1'b0, 24'h000100, 3'd4, 4'd7}   // R7 code 3
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    check(2, "req_ready in reset", {31'b0, req_ready}, 32'd1);
    check(2, "rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(2, "mem_en idle", {31'b0, mem_en}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      txn(VECS[i].addr, VECS[i].size, VECS[i].wr, VECS[i].wdata);
      if (!VECS[i].wr) check(int'(VECS[i].rq), "rdata", got_rd, VECS[i].exp_rd);
      check(int'(VECS[i].rq), "fault", {31'b0, got_fault}, {31'b0, VECS[i].exp_fault});
      check(11, "memory cycles", nacc, {29'b0, VECS[i].exp_nacc});
      check(int'(VECS[i].rq), "first offset", {8'b0, first_off}, {8'b0, VECS[i].exp_off});
    end

    // R10 back-pressure on the response
    nacc = 0; seen = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h00FFE004; req_size = 2'd2; req_write = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(10, "req_ready after accept", {31'b0, req_ready}, 32'd0);
    while (!rsp_valid) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(10, "rsp_valid held", {31'b0, rsp_valid}, 32'd1);
      check(10, "rdata held", rsp_rdata, 32'hCAFEF00D);
      check(10, "req_ready while held", {31'b0, req_ready}, 32'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(10, "req_ready after take", {31'b0, req_ready}, 32'd1);
    check(10, "rsp_valid after take", {31'b0, rsp_valid}, 32'd0);

    // R8 refused load keeps the old windows
    load_cfg(24'h004000, 24'h0F0000, 24'hFF0000);
    txn(32'h001FFFFF, 2'd0, 1'b0, 32'h0);
    check(8, "refused load fault", {31'b0, got_fault}, 32'd0);
    check(8, "refused load offset", {8'b0, first_off}, 32'h00107FFF);
    check(8, "refused load data", got_rd, 32'h00000012);

    // R8 accepted load: rom 0x4000, low end 0x180000, high start 0xFF0000
    load_cfg(24'h004000, 24'h180000, 24'hFF0000);
    txn(32'h001FFFFF, 2'd0, 1'b0, 32'h0);
    check(8, "new low end now gap", {31'b0, got_fault}, 32'd1);
    check(6, "gap no memory cycle", nacc, 32'd0);
    txn(32'h00004010, 2'd0, 1'b0, 32'h0);
    check(3, "rom mirror 16K", {8'b0, first_off}, 32'h00000010);
    txn(32'h00FF0010, 2'd0, 1'b0, 32'h0);
    check(5, "high below mask range", {8'b0, first_off}, 32'h00084010);
    txn(32'h00170000, 2'd0, 1'b0, 32'h0);
    check(4, "relocated with new rom", {8'b0, first_off}, 32'h00074000);

    summary();
    $finish;
  end
endmodule